// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight condition and control bits of a small 8-bit RISC core. The ALU reports its result flags together with a per-flag write mask, so instructions that leave some flags untouched can be modelled exactly. The interrupt sequencer signals interrupt entry and return. Dedicated commands set or clear the global interrupt enable on their own. Bit-store and bit-load instructions pass single bits through a copy bit kept in the register. The register can also be read and written as a whole at one address on the core's I/O bus. Every bit is driven out in parallel to the branch and interrupt logic.

The bit layout, from bit 7 down to bit 0, is: I (global interrupt enable), T (copy bit), H (half carry), S (sign), V (two's complement overflow), N (negative), Z (zero), C (carry). The sign bit is never stored freely. It always equals N xor V of the value being written. On interrupt entry or return the block changes only I; saving and restoring the rest of the register is left to software.

Top module: `cpu_flag_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all eight bits of `status_o` become 0.
- R2: When `alu_upd` is high, each bit whose `alu_mask` bit is 1 takes the matching `alu_flags` bit at the edge, and each bit whose mask bit is 0 keeps its value (bit 4, S, excepted; see R3).
- R3: After every update, bit 4 (S) of `status_o` equals bit 2 (N) xor bit 3 (V); a value offered for bit 4 by the ALU or the bus is ignored.
- R4: `irq_enter` clears bit 7 (I) at the edge, whatever bus write, return or set command arrives in the same cycle.
- R5: `irq_return` or `sei_req` sets bit 7, and `cli_req` clears it, with `cli_req` winning over both; these commands override an ALU value for bit 7.
- R6: A bus write (`bus_we` high with `bus_addr` equal to `REG_IO_ADDR`, 0x3F by default) loads `bus_wdata` into the whole register, overriding the return, set/clear and ALU sources; a write to any other address changes nothing.
- R7: `bus_rdata` shows the register value held before the current edge when `bus_re` is high and `bus_addr` equals `REG_IO_ADDR`, and is 0 otherwise.
- R8: `bst_req` loads bit `bst_sel` of `bst_opnd` into bit 6 (T), over any bus write or ALU value for that bit.
- R9: `bld_result` equals `bld_opnd` with bit `bld_sel` replaced by the current bit 6 (T), in the same cycle.
- R10: Interrupt entry and return alter only bit 7; the other seven bits keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_upd | input | 1 | ALU result flags are valid this cycle |
| alu_flags | input | 8 | Flag values from the ALU, register layout |
| alu_mask | input | 8 | Per-flag write enable for the ALU update |
| irq_enter | input | 1 | An interrupt is being taken |
| irq_return | input | 1 | Return-from-interrupt executed |
| sei_req | input | 1 | Set-interrupt-enable command |
| cli_req | input | 1 | Clear-interrupt-enable command |
| bst_req | input | 1 | Bit-store into the copy bit |
| bst_opnd | input | OPND_W | Register-file operand for bit-store |
| bst_sel | input | SEL_W | Bit position picked by bit-store |
| bld_opnd | input | OPND_W | Register-file operand for bit-load |
| bld_sel | input | SEL_W | Bit position replaced by bit-load |
| bld_result | output | OPND_W | Operand with the copy bit inserted |
| bus_addr | input | BUS_ADDR_W | I/O bus address |
| bus_we | input | 1 | I/O bus write strobe |
| bus_re | input | 1 | I/O bus read strobe |
| bus_wdata | input | 8 | I/O bus write data |
| bus_rdata | output | 8 | I/O bus read data, 0 when not selected |
| status_o | output | 8 | Current flag register |

## Verification
The bench builds the block with its default values: an 8-bit operand, a 6-bit I/O address and the register at 0x3F. With these values every one of the 256 bus write values and every one of the 256 ALU write masks can be swept in full. All eight bit positions of the bit-store and bit-load paths are walked with both copy-bit polarities. The expected value of each sweep point is computed in the bench by masking and by forming the sign from N and V.

// File: rtl/cfr_pkg.sv
// Package: shared constants and helpers for the status flag register.
// Assumes a fixed 8-bit flag layout; bit positions are decoded by branch logic.
package cfr_pkg;
    localparam int unsigned FLAG_W = 8;
    localparam int unsigned POS_C  = 0;
    localparam int unsigned POS_Z  = 1;
    localparam int unsigned POS_N  = 2;
    localparam int unsigned POS_V  = 3;
    localparam int unsigned POS_S  = 4;
    localparam int unsigned POS_H  = 5;
    localparam int unsigned POS_T  = 6;
    localparam int unsigned POS_I  = 7;

    // Replace the sign bit of a flag vector by N xor V.
    function automatic logic [FLAG_W-1:0] fix_sign(input logic [FLAG_W-1:0] v);
        logic [FLAG_W-1:0] r;
        r        = v;
        r[POS_S] = v[POS_N] ^ v[POS_V];
        return r;
    endfunction
endpackage

// File: rtl/cfr_mask_merge.sv
// Module: per-bit merge of an update vector into a current value under a mask.
// Assumes en qualifies the whole update; bits with mask low pass cur through.
module cfr_mask_merge #(
    parameter int unsigned W = 8
) (
    input  logic         en,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] val,
    input  logic [W-1:0] mask,
    output logic [W-1:0] merged
);
    // One select per bit: take the new value only where enabled and masked in.
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign merged[g] = (en && mask[g]) ? val[g] : cur[g];
    end
endmodule

// File: rtl/cfr_irq_enable.sv
// Module: next value of the global interrupt enable from the direct commands.
// Assumes interrupt entry is handled by the caller at higher priority.
module cfr_irq_enable (
    input  logic cur_i,
    input  logic set_req,
    input  logic clr_req,
    output logic touched,
    output logic nxt_i
);
    // Clear wins over set; with neither, the incoming value is kept.
    always_comb begin
        touched = set_req | clr_req;
        if (clr_req)      nxt_i = 1'b0;
        else if (set_req) nxt_i = 1'b1;
        else              nxt_i = cur_i;
    end
endmodule

// File: rtl/cfr_bit_copy.sv
// Module: bit-store source selection and bit-load insertion through the copy bit.
// Assumes OPND_W is a power of two so every select value names a real bit.
module cfr_bit_copy #(
    parameter int unsigned OPND_W = 8,
    parameter int unsigned SEL_W  = $clog2(OPND_W)
) (
    input  logic [OPND_W-1:0] bst_opnd,
    input  logic [SEL_W-1:0]  bst_sel,
    input  logic              t_cur,
    input  logic [OPND_W-1:0] bld_opnd,
    input  logic [SEL_W-1:0]  bld_sel,
    output logic              t_src,
    output logic [OPND_W-1:0] bld_result
);
    // Pick the operand bit that a bit-store would copy into T.
    assign t_src = bst_opnd[bst_sel];

    // Replace the selected operand bit with T for the bit-load write-back.
    for (genvar g = 0; g < OPND_W; g++) begin : g_ins
        assign bld_result[g] = (bld_sel == SEL_W'(g)) ? t_cur : bld_opnd[g];
    end
endmodule

// File: rtl/cfr_bus_decode.sv
// Module: address match for the register's single I/O bus location.
// Assumes strobes are already qualified by the bus master.
module cfr_bus_decode #(
    parameter int unsigned            ADDR_W = 6,
    parameter logic [ADDR_W-1:0]      MATCH  = '1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    output logic              wr_hit,
    output logic              rd_hit
);
    // Qualify each strobe with the address compare.
    always_comb begin
        wr_hit = we && (addr == MATCH);
        rd_hit = re && (addr == MATCH);
    end
endmodule

// File: rtl/cpu_flag_reg.sv
// Module: processor status flag register with ALU, interrupt, copy-bit and bus paths.
// Priority per cycle, highest first: interrupt entry on I, bus write, return and
// set/clear on I, masked ALU update. Bit-store forces T on top of any of them.
// S is always rebuilt as N xor V of the final value. No context save is done here.
module cpu_flag_reg
    import cfr_pkg::*;
#(
    parameter int unsigned           BUS_ADDR_W  = 6,
    parameter logic [BUS_ADDR_W-1:0] REG_IO_ADDR = 6'h3F,
    parameter int unsigned           OPND_W      = 8,
    localparam int unsigned          SEL_W       = $clog2(OPND_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alu_upd,
    input  logic [FLAG_W-1:0]     alu_flags,
    input  logic [FLAG_W-1:0]     alu_mask,
    input  logic                  irq_enter,
    input  logic                  irq_return,
    input  logic                  sei_req,
    input  logic                  cli_req,
    input  logic                  bst_req,
    input  logic [OPND_W-1:0]     bst_opnd,
    input  logic [SEL_W-1:0]      bst_sel,
    input  logic [OPND_W-1:0]     bld_opnd,
    input  logic [SEL_W-1:0]      bld_sel,
    output logic [OPND_W-1:0]     bld_result,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic                  bus_we,
    input  logic                  bus_re,
    input  logic [FLAG_W-1:0]     bus_wdata,
    output logic [FLAG_W-1:0]     bus_rdata,
    output logic [FLAG_W-1:0]     status_o
);
    logic [FLAG_W-1:0] stat_q;
    logic [FLAG_W-1:0] alu_merged;
    logic [FLAG_W-1:0] ctl_val;
    logic [FLAG_W-1:0] stat_d;
    logic              wr_hit;
    logic              rd_hit;
    logic              i_touched;
    logic              i_next;
    logic              t_src;

    cfr_mask_merge #(.W(FLAG_W)) u_merge (
        .en     (alu_upd),
        .cur    (stat_q),
        .val    (alu_flags),
        .mask   (alu_mask),
        .merged (alu_merged)
    );

    cfr_irq_enable u_ien (
        .cur_i   (alu_merged[POS_I]),
        .set_req (irq_return | sei_req),
        .clr_req (cli_req),
        .touched (i_touched),
        .nxt_i   (i_next)
    );

    cfr_bit_copy #(.OPND_W(OPND_W), .SEL_W(SEL_W)) u_copy (
        .bst_opnd   (bst_opnd),
        .bst_sel    (bst_sel),
        .t_cur      (stat_q[POS_T]),
        .bld_opnd   (bld_opnd),
        .bld_sel    (bld_sel),
        .t_src      (t_src),
        .bld_result (bld_result)
    );

    cfr_bus_decode #(.ADDR_W(BUS_ADDR_W), .MATCH(REG_IO_ADDR)) u_dec (
        .addr   (bus_addr),
        .we     (bus_we),
        .re     (bus_re),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    // Apply the direct interrupt-enable commands on top of the ALU result.
    always_comb begin
        ctl_val = alu_merged;
        if (i_touched) ctl_val[POS_I] = i_next;
    end

    // Resolve bus write, bit-store, interrupt entry and the derived sign bit.
    always_comb begin
        stat_d = wr_hit ? bus_wdata : ctl_val;
        if (bst_req)   stat_d[POS_T] = t_src;
        if (irq_enter) stat_d[POS_I] = 1'b0;
        stat_d = fix_sign(stat_d);
    end

    // Hold the flag state; synchronous active-low reset clears every bit.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // Present the held value on the bus only when this location is read.
    assign bus_rdata = rd_hit ? stat_q : '0;
    assign status_o  = stat_q;
endmodule

// File: rtl/cfr_checker.sv
// Module: property checker for the status flag register, bound to the top.
// Assumes the top's default flag layout from cfr_pkg.
module cfr_checker
    import cfr_pkg::*;
#(
    parameter int unsigned           BUS_ADDR_W  = 6,
    parameter logic [BUS_ADDR_W-1:0] REG_IO_ADDR = 6'h3F,
    parameter int unsigned           OPND_W      = 8,
    parameter int unsigned           SEL_W       = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  alu_upd,
    input logic [FLAG_W-1:0]     alu_mask,
    input logic                  irq_enter,
    input logic                  irq_return,
    input logic                  sei_req,
    input logic                  cli_req,
    input logic                  bst_req,
    input logic [OPND_W-1:0]     bst_opnd,
    input logic [SEL_W-1:0]      bst_sel,
    input logic [BUS_ADDR_W-1:0] bus_addr,
    input logic                  bus_we,
    input logic                  bus_re,
    input logic [FLAG_W-1:0]     bus_wdata,
    input logic [FLAG_W-1:0]     bus_rdata,
    input logic [FLAG_W-1:0]     status_o
);
    logic bus_wr;
    logic quiet_other;
    assign bus_wr      = bus_we && (bus_addr == REG_IO_ADDR);
    assign quiet_other = !bus_wr && !bst_req && !alu_upd;

    p_sign_xor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[POS_S] == (status_o[POS_N] ^ status_o[POS_V]));

    p_alu_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_upd && !bus_wr && !bst_req && !irq_enter && !irq_return && !sei_req && !cli_req)
        |=> ((status_o & ~$past(alu_mask) & 8'hEF) == ($past(status_o) & ~$past(alu_mask) & 8'hEF)));

    p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> !status_o[POS_I]);

    p_set_ien_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_return || sei_req) && !cli_req && !irq_enter && !bus_wr) |=> status_o[POS_I]);

    p_clr_ien_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cli_req && !bus_wr) |=> !status_o[POS_I]);

    p_bus_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !irq_enter && !bst_req)
        |=> (status_o == fix_sign($past(bus_wdata))));

    p_rdata_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_re && (bus_addr == REG_IO_ADDR)) |-> (bus_rdata == '0));

    p_bit_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bst_req |=> (status_o[POS_T] == $past(bst_opnd[bst_sel])));

    p_no_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_enter || irq_return) && quiet_other) |=> $stable(status_o[POS_T:0]));
endmodule

bind cpu_flag_reg cfr_checker #(
    .BUS_ADDR_W  (BUS_ADDR_W),
    .REG_IO_ADDR (REG_IO_ADDR),
    .OPND_W      (OPND_W),
    .SEL_W       (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alu_upd    (alu_upd),
    .alu_mask   (alu_mask),
    .irq_enter  (irq_enter),
    .irq_return (irq_return),
    .sei_req    (sei_req),
    .cli_req    (cli_req),
    .bst_req    (bst_req),
    .bst_opnd   (bst_opnd),
    .bst_sel    (bst_sel),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .status_o   (status_o)
);

// File: tb/cpu_flag_reg_tb.sv
// Bench: sweeps write values, ALU masks and copy-bit positions of the flag register.
module cpu_flag_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       alu_upd, irq_enter, irq_return, sei_req, cli_req, bst_req;
    logic [7:0] alu_flags, alu_mask, bst_opnd, bld_opnd, bld_result;
    logic [2:0] bst_sel, bld_sel;
    logic [5:0] bus_addr;
    logic       bus_we, bus_re;
    logic [7:0] bus_wdata, bus_rdata, status_o;
    int         total = 0;
    int         fails = 0;
    bit         done  = 1'b0;

    always #5 clk = ~clk;

    cpu_flag_reg u_dut (
        .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .alu_flags(alu_flags),
        .alu_mask(alu_mask), .irq_enter(irq_enter), .irq_return(irq_return),
        .sei_req(sei_req), .cli_req(cli_req), .bst_req(bst_req),
        .bst_opnd(bst_opnd), .bst_sel(bst_sel), .bld_opnd(bld_opnd),
        .bld_sel(bld_sel), .bld_result(bld_result), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .status_o(status_o)
    );

    function automatic logic [7:0] sfix(input logic [7:0] v);
        logic [7:0] r;
        r    = v;
        r[4] = v[2] ^ v[3];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        alu_upd = 0; alu_flags = 0; alu_mask = 0; irq_enter = 0; irq_return = 0;
        sei_req = 0; cli_req = 0; bst_req = 0; bst_opnd = 0; bst_sel = 0;
        bld_opnd = 0; bld_sel = 0; bus_addr = 0; bus_we = 0; bus_re = 0; bus_wdata = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [7:0] v);
        bus_addr = 6'h3F; bus_we = 1; bus_wdata = v;
        step();
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset value", status_o, 8'h00);
        rst_n = 1;
        bus_addr = 6'h3F; bus_re = 1; #1;
        chk("R7 read after reset", bus_rdata, 8'h00);
        step();

        // R6 and R3: every write value, then read it back through the bus
        for (int v = 0; v < 256; v++) begin
            wr(8'(v));
            chk("R6 R3 bus write", status_o, sfix(8'(v)));
            bus_addr = 6'h3F; bus_re = 1; #1;
            chk("R7 bus read", bus_rdata, sfix(8'(v)));
            idle();
        end

        // R6 write elsewhere ignored, R7 read elsewhere gives 0
        wr(8'h00);
        bus_addr = 6'h3E; bus_we = 1; bus_wdata = 8'hFF; step();
        chk("R6 other address ignored", status_o, 8'h00);
        wr(8'hC3);
        bus_addr = 6'h3E; bus_re = 1; #1;
        chk("R7 other address reads 0", bus_rdata, 8'h00);
        idle();

        // R2: every ALU write mask
        for (int m = 0; m < 256; m++) begin
            logic [7:0] st, vl, mm;
            mm = 8'(m);
            st = sfix(8'h5A ^ mm);
            vl = 8'hC3 ^ {mm[3:0], mm[7:4]};
            wr(st);
            alu_upd = 1; alu_flags = vl; alu_mask = mm; step();
            chk("R2 R3 masked ALU update", status_o, sfix((st & ~mm) | (vl & mm)));
        end

        // R3: ALU offering only S is overruled
        wr(8'h00);
        alu_upd = 1; alu_flags = 8'h10; alu_mask = 8'h10; step();
        chk("R3 S from ALU ignored", status_o, 8'h00);

        // R7: read shows value before the edge
        wr(8'h00);
        bus_addr = 6'h3F; bus_re = 1; alu_upd = 1; alu_flags = 8'hFF; alu_mask = 8'hFF; #1;
        chk("R7 read before edge", bus_rdata, 8'h00);
        step();
        chk("R2 full ALU update", status_o, 8'hEF);

        // R4: entry beats bus write and set command
        wr(8'h80);
        irq_enter = 1; sei_req = 1; bus_addr = 6'h3F; bus_we = 1; bus_wdata = 8'hFF; step();
        chk("R4 entry over write", status_o, 8'h6F);

        // R10 and R4/R5: entry and return touch only I
        wr(8'hAB);
        chk("R3 written sign fixed", status_o, 8'hBB);
        irq_enter = 1; step();
        chk("R4 R10 entry clears only I", status_o, 8'h3B);
        irq_return = 1; step();
        chk("R5 R10 return sets only I", status_o, 8'hBB);

        // R5: command ordering
        wr(8'h80);
        sei_req = 1; cli_req = 1; step();
        chk("R5 clear wins over set", status_o, 8'h00);
        sei_req = 1; step();
        chk("R5 set command", status_o, 8'h80);
        wr(8'h00);
        sei_req = 1; alu_upd = 1; alu_flags = 8'h00; alu_mask = 8'h80; step();
        chk("R5 set over ALU", status_o, 8'h80);
        cli_req = 1; alu_upd = 1; alu_flags = 8'h80; alu_mask = 8'h80; step();
        chk("R5 clear over ALU", status_o, 8'h00);
        irq_return = 1; bus_addr = 6'h3F; bus_we = 1; bus_wdata = 8'h01; step();
        chk("R6 write over return", status_o, 8'h01);

        // R8: every bit position, both polarities, against a bus write
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 2; p++) begin
                logic [7:0] op, w, e;
                op = (p == 1) ? 8'(1 << s) : ~8'(1 << s);
                w  = (p == 1) ? 8'h00 : 8'hFF;
                e  = sfix(w);
                e[6] = (p == 1);
                bst_req = 1; bst_opnd = op; bst_sel = 3'(s);
                bus_addr = 6'h3F; bus_we = 1; bus_wdata = w; step();
                chk("R8 bit store", status_o, e);
            end
        end

        // R9: every bit position, both T values
        for (int t = 0; t < 2; t++) begin
            wr((t == 1) ? 8'h40 : 8'h00);
            for (int s = 0; s < 8; s++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [7:0] op, e;
                    op = (k == 1) ? 8'hA5 : 8'h5A;
                    e  = op;
                    e[s] = (t == 1);
                    bld_opnd = op; bld_sel = 3'(s); #1;
                    chk("R9 bit load", bld_result, e);
                end
            end
            idle();
        end

        // R1: reset again from a full state
        wr(8'hFF);
        rst_n = 0; step();
        chk("R1 reset clears", status_o, 8'h00);
        rst_n = 1;

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired (all requirements)");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule